// File: doc/BRIEF.md
# Serial Bit-Addressed I/O Unit

This unit moves a field of 1 to 16 bits between a processor core and a 4096-bit serial I/O space. The core supplies a 12-bit starting bit address, a field length code, a direction and, for output, a 16-bit value. The unit then walks the field one bit at a time. For each bit it drives a bit address, and for output it also drives a serial data line and a clock strobe. Devices outside the unit, such as addressable bit latches or chains of shift registers, decode the address. They capture data on the strobe or return data on the serial input line.

The data passes through a 16-bit shift register inside the unit. Every bit takes two clock cycles. In the first cycle the address and the output data settle. In the second cycle a strobe pulses on output transfers, or the input line is sampled at the closing edge on input transfers. The address rises by one per bit and wraps from 4095 to 0. When the last bit is finished, the unit raises a one-cycle completion pulse. Requests that arrive while a transfer is running are dropped.

Top module: `sbio_unit`

## Requirements
- R1: After reset `busy`, `done`, `io_strobe` and `io_sout` are 0, `io_addr` is 0 and `rd_data` is 0.
- R2: A request (`req_valid`=1) seen at a clock edge while `busy`=0 starts a transfer. From the next cycle `busy`=1 and `io_addr` equals `req_base`.
- R3: The length code `req_len` gives the field width in bits. A code of 0 means 16 bits. A transfer of n bits keeps `busy` high for exactly 2*n cycles.
- R4: Bit k (k=0 first) is presented for two cycles at address (`req_base`+k) mod 4096. The address holds steady within a bit, rises by one between bits and wraps from 4095 to 0.
- R5: On an output transfer (`req_dir`=1), bit k carries `req_wdata` bit k on `io_sout` in both cycles of that bit, least significant bit first. `io_strobe` is 1 only in the second cycle of each bit, so a field of n bits gives exactly n strobes.
- R6: On an input transfer (`req_dir`=0), `io_sin` is sampled at the clock edge that ends the second cycle of bit k, and the sample becomes `rd_data` bit k. Bits n..15 of `rd_data` are 0. `io_strobe` and `io_sout` stay 0 for the whole transfer.
- R7: In the cycle after the last bit, `busy` is 0 and `done` is 1 for exactly one cycle. `rd_data` is already valid in that cycle for an input transfer.
- R8: A request while `busy`=1 is ignored. The running transfer keeps its address sequence, data, length and direction.
- R9: An output transfer leaves `rd_data` at the value of the last completed input transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request, taken only when idle |
| req_dir | input | 1 | 1 = output to devices, 0 = input from devices |
| req_len | input | 4 | Field width in bits, 0 encodes 16 |
| req_base | input | 12 | Bit address of field bit 0 |
| req_wdata | input | 16 | Output value, bit 0 sent first |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the last bit |
| rd_data | output | 16 | Assembled input field, upper unused bits 0 |
| io_addr | output | 12 | Bit address presented to devices |
| io_sout | output | 1 | Serial output data |
| io_strobe | output | 1 | Output capture strobe, second cycle of each bit |
| io_sin | input | 1 | Serial input data |

## Verification
The bench targets the address wrap from 4095 to 0 in the middle of a field. A design that carried into a 13th bit, or that saturated, would show an address other than 0 after 4095. It checks the 16-bit field selected by code 0, where a design that took the code literally would end at once. It also checks one-bit and short input fields, where a wrong alignment shift would leave stale or shifted bits above bit n-1. A request injected in the middle of an output transfer would restart the address or reload the data if it were not ignored. An output transfer that follows an input transfer would corrupt the held read result if the result register were written on every completion.

// File: rtl/sbio_pkg.sv
package sbio_pkg;
  localparam int SBIO_ADDR_W = 12;
  localparam int SBIO_DATA_W = 16;

  typedef enum logic {
    PH_SETUP  = 1'b0,
    PH_STROBE = 1'b1
  } sbio_phase_e;
endpackage

// File: rtl/sbio_seq.sv
module sbio_seq
  import sbio_pkg::*;
#(
  parameter int DATA_W = SBIO_DATA_W,
  parameter int LEN_W  = $clog2(DATA_W),
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_dir,
  input  logic [LEN_W-1:0] req_len,
  output logic             start,
  output logic             busy,
  output logic             phase_hi,
  output logic             dir_wr,
  output logic             step_end,
  output logic             bit_step,
  output logic             last_step,
  output logic             done,
  output logic [CNT_W-1:0] nbits
);
  // Field width from the length code; 0 (or any code past DATA_W) selects the full width.
  function automatic logic [CNT_W-1:0] len_decode(input logic [LEN_W-1:0] code);
    if (code == '0 || CNT_W'(code) > CNT_W'(DATA_W))
      return CNT_W'(DATA_W);
    else
      return CNT_W'(code);
  endfunction

  logic             busy_q;
  sbio_phase_e      phase_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] nbits_q;
  logic             dir_q;
  logic             done_q;

  assign start     = req_valid && !busy_q;
  assign step_end  = busy_q && (phase_q == PH_STROBE);
  assign last_step = step_end && (idx_q == nbits_q - CNT_W'(1));
  assign bit_step  = step_end && !last_step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= PH_SETUP;
      idx_q   <= '0;
      nbits_q <= CNT_W'(1);
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_step;
      if (start) begin
        busy_q  <= 1'b1;
        phase_q <= PH_SETUP;
        idx_q   <= '0;
        nbits_q <= len_decode(req_len);
        dir_q   <= req_dir;
      end else if (busy_q) begin
        if (phase_q == PH_SETUP) begin
          phase_q <= PH_STROBE;
        end else begin
          phase_q <= PH_SETUP;
          if (last_step) busy_q <= 1'b0;
          else           idx_q  <= idx_q + CNT_W'(1);
        end
      end
    end
  end

  assign busy     = busy_q;
  assign phase_hi = busy_q && (phase_q == PH_STROBE);
  assign dir_wr   = dir_q;
  assign done     = done_q;
  assign nbits    = nbits_q;
endmodule

// File: rtl/sbio_addr.sv
module sbio_addr
  import sbio_pkg::*;
#(
  parameter int ADDR_W = SBIO_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic              bit_step,
  output logic [ADDR_W-1:0] addr
);
  // Next bit address; the space wraps at 2**ADDR_W.
  function automatic logic [ADDR_W-1:0] addr_inc(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        addr_q <= '0;
    else if (start)    addr_q <= base;
    else if (bit_step) addr_q <= addr_inc(addr_q);
  end

  assign addr = addr_q;
endmodule

// File: rtl/sbio_shreg.sv
module sbio_shreg
  import sbio_pkg::*;
#(
  parameter int DATA_W = SBIO_DATA_W,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              load_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dir_wr,
  input  logic              step_end,
  input  logic              last_step,
  input  logic [CNT_W-1:0]  nbits,
  input  logic              sin,
  output logic              sout_bit,
  output logic [DATA_W-1:0] rdata
);
  // Input bits enter at the top, so after n shifts the field sits in the top n bits.
  // Moving it down by DATA_W-n brings bit 0 to position 0 and leaves zeros above.
  function automatic logic [DATA_W-1:0] align_read(input logic [DATA_W-1:0] v,
                                                   input logic [CNT_W-1:0]  n);
    return v >> (CNT_W'(DATA_W) - n);
  endfunction

  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_next;
  logic [DATA_W-1:0] rd_q;

  assign sh_next = {(dir_wr ? 1'b0 : sin), sh_q[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q <= '0;
      rd_q <= '0;
    end else begin
      if (start)         sh_q <= load_wr ? wdata : '0;
      else if (step_end) sh_q <= sh_next;
      if (last_step && !dir_wr) rd_q <= align_read(sh_next, nbits);
    end
  end

  assign sout_bit = sh_q[0];
  assign rdata    = rd_q;
endmodule

// File: rtl/sbio_unit.sv
module sbio_unit
  import sbio_pkg::*;
#(
  parameter int ADDR_W = SBIO_ADDR_W,
  parameter int DATA_W = SBIO_DATA_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_dir,
  input  logic [$clog2(DATA_W)-1:0] req_len,
  input  logic [ADDR_W-1:0]         req_base,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      busy,
  output logic                      done,
  output logic [DATA_W-1:0]         rd_data,
  output logic [ADDR_W-1:0]         io_addr,
  output logic                      io_sout,
  output logic                      io_strobe,
  input  logic                      io_sin
);
  localparam int LEN_W = $clog2(DATA_W);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic             start;
  logic             phase_hi;
  logic             dir_wr;
  logic             step_end;
  logic             bit_step;
  logic             last_step;
  logic [CNT_W-1:0] nbits;
  logic             sout_bit;

  sbio_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dir(req_dir),
    .req_len(req_len), .start(start), .busy(busy), .phase_hi(phase_hi),
    .dir_wr(dir_wr), .step_end(step_end), .bit_step(bit_step),
    .last_step(last_step), .done(done), .nbits(nbits)
  );

  sbio_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .start(start), .base(req_base),
    .bit_step(bit_step), .addr(io_addr)
  );

  sbio_shreg #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .start(start), .load_wr(req_dir),
    .wdata(req_wdata), .dir_wr(dir_wr), .step_end(step_end),
    .last_step(last_step), .nbits(nbits), .sin(io_sin),
    .sout_bit(sout_bit), .rdata(rd_data)
  );

  assign io_sout   = busy && dir_wr && sout_bit;
  assign io_strobe = phase_hi && dir_wr;
endmodule

// File: rtl/sbio_chk.sv
module sbio_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              io_strobe,
  input logic              io_sout,
  input logic [ADDR_W-1:0] io_addr,
  input logic              bit_step,
  input logic              dir_wr,
  input logic              phase_hi
);
  // R5
  strobe_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_strobe |-> (busy && dir_wr && phase_hi));

  // R6
  quiet_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dir_wr) |-> (!io_strobe && !io_sout));

  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_hi |-> $stable(io_addr));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_step |=> (io_addr == ADDR_W'($past(io_addr) + ADDR_W'(1))));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_step) |=> $stable(io_addr));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind sbio_unit sbio_chk #(.ADDR_W(ADDR_W)) u_sbio_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .io_strobe(io_strobe),
  .io_sout(io_sout), .io_addr(io_addr), .bit_step(bit_step), .dir_wr(dir_wr),
  .phase_hi(phase_hi)
);

// File: tb/test_sbio_unit.sv
module test_sbio_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_dir = 1'b0;
  logic [3:0]  req_len = '0;
  logic [11:0] req_base = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, io_sout, io_strobe;
  logic [15:0] rd_data;
  logic [11:0] io_addr;
  logic        io_sin = 1'b0;

  int nchecks = 0;
  int nerrors = 0;
  logic [15:0] last_rd = '0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbio_unit i_sbio_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dir(req_dir),
    .req_len(req_len), .req_base(req_base), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .io_addr(io_addr),
    .io_sout(io_sout), .io_strobe(io_strobe), .io_sin(io_sin)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerrors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int field_len(input logic [3:0] code);
    return (code == 4'd0) ? 16 : int'(code);
  endfunction

  function automatic logic [15:0] field_mask(input int n);
    logic [15:0] m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic test_reset();
    @(negedge clk);
    check("R1 busy", 32'(busy), 0);
    check("R1 done", 32'(done), 0);
    check("R1 strobe", 32'(io_strobe), 0);
    check("R1 sout", 32'(io_sout), 0);
    check("R1 addr", 32'(io_addr), 0);
    check("R1 rd_data", 32'(rd_data), 0);
  endtask

  task automatic run_write(input logic [11:0] base, input logic [3:0] code,
                           input logic [15:0] data, input bit poke);
    int n = field_len(code);
    logic [11:0] ea;
    req_valid = 1'b1; req_dir = 1'b1; req_base = base; req_len = code; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 busy after request", 32'(busy), 1);
    for (int k = 0; k < n; k++) begin
      ea = base + 12'(k);
      check("R4 addr setup", 32'(io_addr), 32'(ea));
      check("R5 sout setup", 32'(io_sout), 32'(data[k]));
      check("R5 no strobe in setup", 32'(io_strobe), 0);
      check("R3 busy during field", 32'(busy), 1);
      if (poke && k == 1) begin
        // R8: a request during the transfer must be dropped
        req_valid = 1'b1; req_dir = 1'b0; req_base = ~base; req_len = code + 4'd3;
        req_wdata = ~data;
      end
      @(negedge clk);
      req_valid = 1'b0;
      check("R4 addr strobe", 32'(io_addr), 32'(ea));
      check("R5 sout strobe", 32'(io_sout), 32'(data[k]));
      check("R5 strobe", 32'(io_strobe), 1);
      @(negedge clk);
    end
    check("R3 busy low after field", 32'(busy), 0);
    check("R7 done", 32'(done), 1);
    check("R9 rd_data kept", 32'(rd_data), 32'(last_rd));
    @(negedge clk);
    check("R7 done single", 32'(done), 0);
    check("R5 no strobe idle", 32'(io_strobe), 0);
  endtask

  task automatic run_read(input logic [11:0] base, input logic [3:0] code,
                          input logic [15:0] pattern);
    int n = field_len(code);
    logic [11:0] ea;
    req_valid = 1'b1; req_dir = 1'b0; req_base = base; req_len = code; req_wdata = 16'hFFFF;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 busy after request", 32'(busy), 1);
    for (int k = 0; k < n; k++) begin
      ea = base + 12'(k);
      io_sin = pattern[k];
      check("R4 addr setup", 32'(io_addr), 32'(ea));
      check("R6 no strobe", 32'(io_strobe), 0);
      check("R6 sout low", 32'(io_sout), 0);
      @(negedge clk);
      check("R4 addr sample", 32'(io_addr), 32'(ea));
      check("R6 no strobe", 32'(io_strobe), 0);
      check("R3 busy during field", 32'(busy), 1);
      @(negedge clk);
      io_sin = ~pattern[k];
    end
    check("R3 busy low after field", 32'(busy), 0);
    check("R7 done", 32'(done), 1);
    check("R6 rd_data", 32'(rd_data), 32'(pattern & field_mask(n)));
    last_rd = pattern & field_mask(n);
    @(negedge clk);
    check("R7 done single", 32'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_write(12'h010, 4'd5, 16'hA5B3, 1'b0);
    run_write(12'hFF8, 4'd0, 16'h9C6E, 1'b0);
    run_read(12'h123, 4'd3, 16'hFFFD);
    run_read(12'hFFF, 4'd0, 16'hC3A5);
    run_read(12'h7FF, 4'd1, 16'hFFFF);
    run_write(12'h400, 4'd7, 16'h0055, 1'b1);
    run_read(12'hFFE, 4'd9, 16'h0F0A);
    run_write(12'h000, 4'd15, 16'h6D21, 1'b0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchecks++;
      nerrors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
      $finish;
    end
  end
endmodule